// File: doc/BRIEF.md
# Direct-Mapped Address Translation Cache

This block caches virtual-to-physical translations for a 64-bit virtual address space with 4 KiB base pages and a multi-level page table. It has 64 slots, and each slot is either empty or holds one translation. A slot is chosen by the six address bits just above the page offset. No replacement choice is ever made: a new translation always lands in its indexed slot and evicts whatever was there before.

A lookup presents an address-space identifier and a virtual address. Within the same cycle it returns a hit flag, the slot number, the stored page-table entry and its address, the global flag, the fill timestamp and the translated physical address. A fill takes a finished page walk: the faulting address, the physical base, the PTE and its address, the walk level and the global flag. It builds the masks for a base page or a superpage and writes the slot picked by the faulting address. As a result, one superpage can end up copied into several slots.

Invalidation comes in two forms. The first is a shootdown, which scans all slots in one clock under an optional address filter and an optional identifier filter. The second is a global clear, driven by reset or by an init pulse.

Top module: `tlb_direct`

## Requirements
- R1: After reset, and in the cycle after `init_i`, every lookup misses. `init_i` overrides a fill or a shootdown issued in the same cycle.
- R2: The slot is `lk_vaddr_i[17:12]`, and `lk_slot_o` reports it. A lookup examines only that slot.
- R3: A fill at walk level L covers S = 12 + 9·L low bits. Bits of the address above S are kept. On a hit, `lk_paddr_o` = (stored physical base with its low S bits cleared) OR (request address AND the low-S mask), so the 12-bit page offset always passes through unchanged.
- R4: A hit requires a valid slot, (global flag set, or stored identifier equal to `lk_asid_i`), and the request address agreeing with the stored virtual address on every bit at or above S.
- R5: A fill writes only the slot selected by its faulting address, even for a superpage, and replaces any previous occupant. Another address inside the same superpage that indexes a different slot misses until that slot is filled as well.
- R6: On a hit, the block returns the PTE, the PTE address, the global flag and the timestamp stored at the fill. The timestamp is the free-running cycle count, which is 0 in reset and increments on each clock after reset, taken in the fill cycle. On a miss, all returned fields are zero.
- R7: A shootdown with neither filter enabled empties every slot.
- R8: A shootdown with only the address filter empties each slot whose stored virtual address equals the filter address masked by that slot's match mask.
- R9: A shootdown with only the identifier filter empties non-global slots holding that identifier. Global slots survive.
- R10: A shootdown with both filters empties only the slots that meet both conditions.
- R11: When a fill and a shootdown occur in the same cycle, the shootdown applies first, so the filled slot survives.
- R12: Fills and shootdowns take effect at the clock edge and are visible to lookups in the next cycle. A lookup reads registered storage with no latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| init_i | input | 1 | Clear all slots |
| lk_asid_i | input | 16 | Lookup address-space identifier |
| lk_vaddr_i | input | 64 | Lookup virtual address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_slot_o | output | 6 | Indexed slot |
| lk_paddr_o | output | 64 | Translated physical address |
| lk_pte_o | output | 64 | Stored PTE |
| lk_pte_addr_o | output | 64 | Stored PTE address |
| lk_global_o | output | 1 | Stored global flag |
| lk_age_o | output | 64 | Fill timestamp |
| fill_i | input | 1 | Install a translation |
| fill_asid_i | input | 16 | Identifier for the fill |
| fill_vaddr_i | input | 64 | Faulting virtual address |
| fill_paddr_i | input | 64 | Physical address from the walk |
| fill_pte_i | input | 64 | Leaf PTE |
| fill_pte_addr_i | input | 64 | Address of the leaf PTE |
| fill_level_i | input | 2 | Walk level of the leaf (0 = 4 KiB) |
| fill_global_i | input | 1 | Global mapping |
| flush_i | input | 1 | Shootdown request |
| flush_by_asid_i | input | 1 | Enable the identifier filter |
| flush_asid_i | input | 16 | Identifier filter value |
| flush_by_addr_i | input | 1 | Enable the address filter |
| flush_vaddr_i | input | 64 | Address filter value |

## Verification
Every stored fact is visible on the lookup port in the cycle after the edge that wrote it, so any corruption in the storage shows up at the first lookup that indexes the damaged slot. A bad mask shows up as a wrong upper physical address, or as a wrong hit or miss, for addresses near a superpage boundary. A wrong shootdown selection shows up as a stale hit, or as a lost global entry, on the next lookup with a matching identifier. The checks compare each lookup against a bench-side copy of the slots. Random addresses are drawn from a narrow pool so that index collisions, superpage overlap and identifier conflicts occur often.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned ADDR_W = 64;
  localparam int unsigned ASID_W = 16;
  localparam int unsigned PTE_W  = 64;
  localparam int unsigned AGE_W  = 64;

  typedef struct packed {
    logic [ASID_W-1:0] asid;
    logic              global;
    logic [PTE_W-1:0]  pte;
    logic [ADDR_W-1:0] pte_addr;
    logic [ADDR_W-1:0] addr_mask;
    logic [ADDR_W-1:0] match_mask;
    logic [ADDR_W-1:0] vaddr;
    logic [ADDR_W-1:0] paddr;
    logic [AGE_W-1:0]  age;
  } tlb_entry_t;
endpackage

// File: rtl/tlb_mask_gen.sv
module tlb_mask_gen #(
  parameter int unsigned ADDR_W     = 64,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned LEVEL_BITS = 9,
  parameter int unsigned LEVEL_W    = 2
) (
  input  logic [LEVEL_W-1:0] level_i,
  output logic [ADDR_W-1:0]  addr_mask_o,
  output logic [ADDR_W-1:0]  match_mask_o
);
  logic [31:0] shift;

  always_comb begin
    shift = PAGE_BITS + 32'(level_i) * LEVEL_BITS;
    // saturate: a shift of the full width covers the whole space
    if (shift >= ADDR_W) addr_mask_o = '1;
    else                 addr_mask_o = (ADDR_W'(1) << shift) - ADDR_W'(1);
    match_mask_o = ~addr_mask_o;
  end
endmodule

// File: rtl/tlb_flush_sel.sv
module tlb_flush_sel
  import tlb_pkg::*;
(
  input  logic              valid_i,
  input  tlb_entry_t        ent_i,
  input  logic              by_asid_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              by_addr_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  output logic              kill_o
);
  logic addr_ok, asid_ok;

  always_comb begin
    addr_ok = !by_addr_i || ((vaddr_i & ent_i.match_mask) == ent_i.vaddr);
    asid_ok = !by_asid_i || (!ent_i.global && (ent_i.asid == asid_i));
    kill_o  = valid_i && addr_ok && asid_ok;
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 64,
  parameter int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  tlb_entry_t        wr_ent_i,
  input  logic              flush_i,
  input  logic              flush_by_asid_i,
  input  logic [ASID_W-1:0] flush_asid_i,
  input  logic              flush_by_addr_i,
  input  logic [ADDR_W-1:0] flush_vaddr_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic              rd_valid_o,
  output tlb_entry_t        rd_ent_o
);
  logic [NUM_SLOTS-1:0] valid_q;
  tlb_entry_t           ent_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] kill;

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    tlb_flush_sel i_sel (
      .valid_i   (valid_q[g]),
      .ent_i     (ent_q[g]),
      .by_asid_i (flush_by_asid_i),
      .asid_i    (flush_asid_i),
      .by_addr_i (flush_by_addr_i),
      .vaddr_i   (flush_vaddr_i),
      .kill_o    (kill[g])
    );
  end

  // priority: init > fill > shootdown
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < NUM_SLOTS; i++) ent_q[i] <= '0;
    end else if (init_i) begin
      valid_q <= '0;
    end else begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (wr_i && (wr_idx_i == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          ent_q[i]   <= wr_ent_i;
        end else if (flush_i && kill[i]) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_ent_o   = ent_q[rd_idx_i];
endmodule

// File: rtl/tlb_direct.sv
module tlb_direct
  import tlb_pkg::*;
#(
  parameter int unsigned NUM_SLOTS  = 64,
  parameter int unsigned PAGE_BITS  = 12,
  parameter int unsigned LEVEL_BITS = 9,
  parameter int unsigned LEVEL_W    = 2,
  localparam int unsigned IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               init_i,
  input  logic [ASID_W-1:0]  lk_asid_i,
  input  logic [ADDR_W-1:0]  lk_vaddr_i,
  output logic               lk_hit_o,
  output logic [IDX_W-1:0]   lk_slot_o,
  output logic [ADDR_W-1:0]  lk_paddr_o,
  output logic [PTE_W-1:0]   lk_pte_o,
  output logic [ADDR_W-1:0]  lk_pte_addr_o,
  output logic               lk_global_o,
  output logic [AGE_W-1:0]   lk_age_o,
  input  logic               fill_i,
  input  logic [ASID_W-1:0]  fill_asid_i,
  input  logic [ADDR_W-1:0]  fill_vaddr_i,
  input  logic [ADDR_W-1:0]  fill_paddr_i,
  input  logic [PTE_W-1:0]   fill_pte_i,
  input  logic [ADDR_W-1:0]  fill_pte_addr_i,
  input  logic [LEVEL_W-1:0] fill_level_i,
  input  logic               fill_global_i,
  input  logic               flush_i,
  input  logic               flush_by_asid_i,
  input  logic [ASID_W-1:0]  flush_asid_i,
  input  logic               flush_by_addr_i,
  input  logic [ADDR_W-1:0]  flush_vaddr_i
);
  logic [AGE_W-1:0]  cycle_q;
  logic [ADDR_W-1:0] fill_amask, fill_mmask;
  tlb_entry_t        fill_ent, rd_ent;
  logic              rd_valid, hit;
  logic [IDX_W-1:0]  lk_idx, fill_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cycle_q <= '0;
    else         cycle_q <= cycle_q + AGE_W'(1);
  end

  tlb_mask_gen #(
    .ADDR_W     (ADDR_W),
    .PAGE_BITS  (PAGE_BITS),
    .LEVEL_BITS (LEVEL_BITS),
    .LEVEL_W    (LEVEL_W)
  ) i_mask (
    .level_i      (fill_level_i),
    .addr_mask_o  (fill_amask),
    .match_mask_o (fill_mmask)
  );

  assign fill_idx = fill_vaddr_i[PAGE_BITS +: IDX_W];
  assign lk_idx   = lk_vaddr_i[PAGE_BITS +: IDX_W];

  always_comb begin
    fill_ent.asid       = fill_asid_i;
    fill_ent.global     = fill_global_i;
    fill_ent.pte        = fill_pte_i;
    fill_ent.pte_addr   = fill_pte_addr_i;
    fill_ent.addr_mask  = fill_amask;
    fill_ent.match_mask = fill_mmask;
    fill_ent.vaddr      = fill_vaddr_i & fill_mmask;
    fill_ent.paddr      = fill_paddr_i & fill_mmask;
    fill_ent.age        = cycle_q;
  end

  tlb_store #(
    .NUM_SLOTS (NUM_SLOTS),
    .IDX_W     (IDX_W)
  ) i_store (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .init_i          (init_i),
    .wr_i            (fill_i),
    .wr_idx_i        (fill_idx),
    .wr_ent_i        (fill_ent),
    .flush_i         (flush_i),
    .flush_by_asid_i (flush_by_asid_i),
    .flush_asid_i    (flush_asid_i),
    .flush_by_addr_i (flush_by_addr_i),
    .flush_vaddr_i   (flush_vaddr_i),
    .rd_idx_i        (lk_idx),
    .rd_valid_o      (rd_valid),
    .rd_ent_o        (rd_ent)
  );

  always_comb begin
    hit = rd_valid
       && (rd_ent.global || (rd_ent.asid == lk_asid_i))
       && ((lk_vaddr_i & rd_ent.match_mask) == rd_ent.vaddr);
    lk_hit_o      = hit;
    lk_slot_o     = lk_idx;
    lk_paddr_o    = hit ? (rd_ent.paddr | (lk_vaddr_i & rd_ent.addr_mask)) : '0;
    lk_pte_o      = hit ? rd_ent.pte : '0;
    lk_pte_addr_o = hit ? rd_ent.pte_addr : '0;
    lk_global_o   = hit && rd_ent.global;
    lk_age_o      = hit ? rd_ent.age : '0;
  end
endmodule

// File: rtl/tlb_direct_chk.sv
module tlb_direct_chk
  import tlb_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 12,
  parameter int unsigned IDX_W     = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              init_i,
  input logic [ASID_W-1:0] lk_asid_i,
  input logic [ADDR_W-1:0] lk_vaddr_i,
  input logic              lk_hit_o,
  input logic [IDX_W-1:0]  lk_slot_o,
  input logic [ADDR_W-1:0] lk_paddr_o,
  input logic              lk_global_o,
  input logic              fill_i,
  input logic [ASID_W-1:0] fill_asid_i,
  input logic [ADDR_W-1:0] fill_vaddr_i,
  input logic              flush_i,
  input logic              flush_by_asid_i,
  input logic [ASID_W-1:0] flush_asid_i,
  input logic              flush_by_addr_i
);
  a_r1_init_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> !lk_hit_o);

  a_r2_slot_from_vpn: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_slot_o == lk_vaddr_i[PAGE_BITS +: IDX_W]);

  a_r3_offset_passes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> lk_paddr_o[PAGE_BITS-1:0] == lk_vaddr_i[PAGE_BITS-1:0]);

  a_r7_flush_all_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && !flush_by_asid_i && !flush_by_addr_i && !fill_i |=> !lk_hit_o);

  a_r9_asid_flush_spares_global: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i && flush_by_asid_i && !flush_by_addr_i && !fill_i
    |=> !(lk_hit_o && lk_asid_i == $past(flush_asid_i)) || lk_global_o);

  a_r11_fill_survives_flush: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_i && !init_i
    |=> !(lk_vaddr_i == $past(fill_vaddr_i) && lk_asid_i == $past(fill_asid_i)) || lk_hit_o);
endmodule

bind tlb_direct tlb_direct_chk #(.PAGE_BITS(PAGE_BITS), .IDX_W(IDX_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .init_i          (init_i),
  .lk_asid_i       (lk_asid_i),
  .lk_vaddr_i      (lk_vaddr_i),
  .lk_hit_o        (lk_hit_o),
  .lk_slot_o       (lk_slot_o),
  .lk_paddr_o      (lk_paddr_o),
  .lk_global_o     (lk_global_o),
  .fill_i          (fill_i),
  .fill_asid_i     (fill_asid_i),
  .fill_vaddr_i    (fill_vaddr_i),
  .flush_i         (flush_i),
  .flush_by_asid_i (flush_by_asid_i),
  .flush_asid_i    (flush_asid_i),
  .flush_by_addr_i (flush_by_addr_i)
);

// File: tb/test_tlb_direct.sv
`timescale 1ns/1ps
module test_tlb_direct;
  localparam int NS = 64;

  logic        clk_i = 1'b0, rst_ni = 1'b0, init_i = 1'b0;
  logic [15:0] lk_asid_i = '0;
  logic [63:0] lk_vaddr_i = '0;
  logic        lk_hit_o, lk_global_o;
  logic [5:0]  lk_slot_o;
  logic [63:0] lk_paddr_o, lk_pte_o, lk_pte_addr_o, lk_age_o;
  logic        fill_i = 1'b0, fill_global_i = 1'b0;
  logic [15:0] fill_asid_i = '0;
  logic [63:0] fill_vaddr_i = '0, fill_paddr_i = '0, fill_pte_i = '0, fill_pte_addr_i = '0;
  logic [1:0]  fill_level_i = '0;
  logic        flush_i = 1'b0, flush_by_asid_i = 1'b0, flush_by_addr_i = 1'b0;
  logic [15:0] flush_asid_i = '0;
  logic [63:0] flush_vaddr_i = '0;

  int vectors = 0, fails = 0;
  logic [63:0] cyc = '0;

  always #2 clk_i = ~clk_i;
  always @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cyc <= '0; else cyc <= cyc + 64'd1;

  tlb_direct i_tlb_direct (.*);

  // bench copy of the slots
  logic        m_v [NS];
  logic [15:0] m_asid [NS];
  logic        m_g [NS];
  logic [63:0] m_pte [NS], m_pta [NS], m_va [NS], m_pa [NS], m_age [NS];
  int          m_sh [NS];

  function automatic logic [63:0] lowmask(input int sh);
    return (sh >= 64) ? '1 : ((64'd1 << sh) - 64'd1);
  endfunction

  task automatic report(input bit ok, input string req, input string act, input string exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  // drive a lookup, compare against the bench copy before the next edge
  task automatic look(input logic [15:0] asid, input logic [63:0] va, input string req);
    int          ix;
    logic        eh, eg;
    logic [63:0] epa, epte, epta, eage;
    lk_asid_i  = asid;
    lk_vaddr_i = va;
    ix   = int'(va[17:12]);
    eh   = m_v[ix] && (m_g[ix] || m_asid[ix] == asid) && ((va & ~lowmask(m_sh[ix])) == m_va[ix]);
    epa  = eh ? (m_pa[ix] | (va & lowmask(m_sh[ix]))) : '0;
    epte = eh ? m_pte[ix] : '0;
    epta = eh ? m_pta[ix] : '0;
    eg   = eh && m_g[ix];
    eage = eh ? m_age[ix] : '0;
    #1;
    report(lk_hit_o == eh && lk_slot_o == va[17:12] && lk_paddr_o == epa && lk_pte_o == epte &&
           lk_pte_addr_o == epta && lk_global_o == eg && lk_age_o == eage, req,
           $sformatf("hit=%0b slot=%0d pa=%h pte=%h pta=%h g=%0b age=%0d", lk_hit_o, lk_slot_o,
                     lk_paddr_o, lk_pte_o, lk_pte_addr_o, lk_global_o, lk_age_o),
           $sformatf("hit=%0b slot=%0d pa=%h pte=%h pta=%h g=%0b age=%0d", eh, va[17:12],
                     epa, epte, epta, eg, eage));
  endtask

  task automatic set_fill(input logic [15:0] asid, input logic [63:0] va, input logic [63:0] pa,
                          input logic [1:0] lvl, input logic g);
    fill_i = 1'b1; fill_asid_i = asid; fill_vaddr_i = va; fill_paddr_i = pa;
    fill_level_i = lvl; fill_global_i = g;
    fill_pte_i = {va[31:0], pa[31:0]} ^ 64'h5A5A;
    fill_pte_addr_i = pa ^ {va[15:0], 48'h0} ^ 64'h0000_8000_0000_0000;
  endtask

  task automatic set_flush(input logic ba, input logic [15:0] asid, input logic bd, input logic [63:0] va);
    flush_i = 1'b1; flush_by_asid_i = ba; flush_asid_i = asid; flush_by_addr_i = bd; flush_vaddr_i = va;
  endtask

  // one clock: apply the bench copy in order init > (shootdown then fill)
  task automatic tick();
    logic [63:0] stamp;
    stamp = cyc;
    @(posedge clk_i);
    if (init_i) begin
      for (int i = 0; i < NS; i++) m_v[i] = 1'b0;
    end else begin
      if (flush_i)
        for (int i = 0; i < NS; i++)
          if (m_v[i] &&
              (!flush_by_addr_i || ((flush_vaddr_i & ~lowmask(m_sh[i])) == m_va[i])) &&
              (!flush_by_asid_i || (!m_g[i] && m_asid[i] == flush_asid_i)))
            m_v[i] = 1'b0;
      if (fill_i) begin
        int ix, sh;
        ix = int'(fill_vaddr_i[17:12]);
        sh = 12 + 9 * int'(fill_level_i);
        m_v[ix] = 1'b1; m_asid[ix] = fill_asid_i; m_g[ix] = fill_global_i;
        m_pte[ix] = fill_pte_i; m_pta[ix] = fill_pte_addr_i; m_sh[ix] = sh;
        m_va[ix] = fill_vaddr_i & ~lowmask(sh);
        m_pa[ix] = fill_paddr_i & ~lowmask(sh);
        m_age[ix] = stamp;
      end
    end
    @(negedge clk_i);
    fill_i = 1'b0; flush_i = 1'b0; init_i = 1'b0;
  endtask

  logic [63:0] hi_pool [2];
  function automatic logic [63:0] rnd_va();
    logic [63:0] v;
    v[63:30] = hi_pool[$urandom % 2][63:30];
    v[29:21] = 9'($urandom % 3);
    v[20:18] = 3'($urandom % 2);
    v[17:12] = 6'($urandom % 8);
    v[11:0]  = 12'($urandom);
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [63:0] a, b, c;
    void'($urandom(32'h1D2C3B4A));
    hi_pool[0] = 64'hFFFF_FFC0_0000_0000;
    hi_pool[1] = 64'h0000_0012_4000_0000;
    for (int i = 0; i < NS; i++) begin
      m_v[i] = 1'b0; m_asid[i] = '0; m_g[i] = 1'b0; m_pte[i] = '0; m_pta[i] = '0;
      m_va[i] = '0; m_pa[i] = '0; m_age[i] = '0; m_sh[i] = 12;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    look(16'd0, 64'h0, "R1 reset miss"); tick();
    look(16'd7, 64'h0000_0012_4003_F123, "R1 reset miss"); tick();

    // R2 R6 base page
    a = 64'h0000_0012_4000_5ABC;
    set_fill(16'd5, a, 64'h0000_0000_8765_4000, 2'd0, 1'b0); tick();
    look(16'd5, a, "R2 R6 base page hit, R12 next cycle"); tick();
    look(16'd5, a ^ 64'h0000_0000_0000_0FFF, "R3 offset passes"); tick();
    look(16'd6, a, "R4 foreign identifier miss"); tick();
    look(16'd5, a ^ 64'h0000_0000_0004_0000, "R4 upper bits differ miss"); tick();

    // R4 global
    b = 64'h0000_0012_4000_9010;
    set_fill(16'd1, b, 64'h0000_0000_1111_1000, 2'd0, 1'b1); tick();
    look(16'd9, b, "R4 global hit any identifier"); tick();

    // R5 superpage lands in one slot only
    c = 64'hFFFF_FFC0_0020_3444;
    set_fill(16'd2, c, 64'h0000_0000_4020_0000, 2'd1, 1'b0); tick();
    look(16'd2, c ^ 64'h0000_0000_0010_0000, "R3 superpage offset inside 2 MiB"); tick();
    look(16'd2, (c & ~64'h3F000) | 64'h7000, "R5 superpage other slot miss"); tick();
    set_fill(16'd2, (c & ~64'h3F000) | 64'h7000, 64'h0000_0000_4020_0000, 2'd1, 1'b0); tick();
    look(16'd2, (c & ~64'h3F000) | 64'h7123, "R5 second slot filled hit"); tick();
    set_fill(16'd3, a ^ 64'h0000_0000_4000_0000, 64'h0000_0000_2222_2000, 2'd0, 1'b0); tick();
    look(16'd5, a, "R5 overwrite evicts"); tick();
    look(16'd3, a ^ 64'h0000_0000_4000_0000, "R5 new occupant hit"); tick();

    // shootdowns
    set_fill(16'd4, 64'h0000_0012_4000_A000, 64'h0000_0000_3333_3000, 2'd0, 1'b0); tick();
    set_flush(1'b1, 16'd1, 1'b0, '0); tick();
    look(16'd9, b, "R9 identifier shootdown spares global"); tick();
    set_flush(1'b0, '0, 1'b1, 64'h0000_0012_4000_9FFF); tick();
    look(16'd9, b, "R8 address shootdown"); tick();
    set_flush(1'b1, 16'd7, 1'b1, 64'h0000_0012_4000_A000); tick();
    look(16'd4, 64'h0000_0012_4000_A000, "R10 both filters, identifier differs, kept"); tick();
    set_flush(1'b1, 16'd4, 1'b1, 64'h0000_0012_4000_A000); tick();
    look(16'd4, 64'h0000_0012_4000_A000, "R10 both filters match, cleared"); tick();
    set_flush(1'b0, '0, 1'b0, '0); tick();
    look(16'd2, c, "R7 full shootdown"); tick();

    // R11 fill with shootdown, init with fill
    set_flush(1'b0, '0, 1'b0, '0);
    set_fill(16'd8, a, 64'h0000_0000_9999_9000, 2'd2, 1'b0); tick();
    look(16'd8, a, "R11 fill beats shootdown"); tick();
    init_i = 1'b1;
    set_fill(16'd8, b, 64'h0000_0000_9999_9000, 2'd0, 1'b0); tick();
    look(16'd8, b, "R1 init beats fill"); tick();
    look(16'd8, a, "R1 init clears"); tick();

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = int'($urandom % 100);
      if (op < 45)
        set_fill(16'($urandom % 3), rnd_va(), {$urandom, $urandom}, 2'($urandom % 3), ($urandom % 5) == 0);
      if (op >= 45 && op < 55)
        set_flush(($urandom % 2) == 1, 16'($urandom % 3), ($urandom % 4) != 0, rnd_va());
      if (op == 55 && ($urandom % 8) == 0) init_i = 1'b1;
      look(16'($urandom % 3), rnd_va(), "R4 R8 R12 random");
      tick();
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule